// File: doc/BRIEF.md
# DDR SDRAM Refresh and Low-Power Sequencer

This block sits on the controller side of a DDR SDRAM interface. It keeps the memory refreshed by issuing auto-refresh commands on a programmable cycle interval. It takes the memory into and out of self-refresh and power-down when a requester asks for it. It owns the clock-enable level towards the memory. It presents one command strobe with a command code in each cycle, and it raises that strobe in at most one cycle at a time.

A downstream command scheduler does not track refresh or low-power timing on its own. It watches three permit outputs instead. One allows row activation and mode-register writes. One allows the other non-read commands. One allows reads. After a refresh, only activation and mode-register writes wait for the refresh recovery time. After a self-refresh exit, non-read commands wait a short, clock-speed-dependent time, and reads wait for a much longer settling time. A refresh is forced as soon as the short exit wait ends. While the memory is in power-down, no refresh is issued. A refresh that falls due during power-down is issued right after the exit wait.

The requester drives entry and exit requests as levels. It holds a request high until it sees the matching command on the strobe. The block delays an entry request while a refresh recovery wait is running.

Top module: `refresh_lp_seq`

## Requirements
- R1: After reset, cke is 1, cmdValid is 0 and cmdCode is 0. All three permits stay 0 until the first auto-refresh has been issued.
- R2: An auto-refresh is issued when the interval counter reaches refInterval. The first one comes refInterval cycles after the first cycle out of reset. Later ones come every refInterval cycles after the previous one. Lowering refInterval below the elapsed count makes a refresh due in that same cycle.
- R3: After an auto-refresh cycle, permitActMrs stays 0 for RFC_CYC-1 cycles and may return RFC_CYC cycles after the refresh. permitNonRead and permitRead are not held off by this wait.
- R4: A self-refresh entry drives cke 0 in the entry cycle. cke stays 0, with no command, until the self-refresh exit cycle, which drives cke 1. No auto-refresh is issued during self-refresh.
- R5: After a self-refresh exit, permitNonRead and permitActMrs stay 0 until EXIT_WAIT_SLOW (10) cycles after the exit when fastClk is 0. With fastClk at 1, the wait is EXIT_WAIT_FAST (12) cycles.
- R6: After a self-refresh exit, permitRead stays 0 until READ_SETTLE (200) cycles after the exit cycle.
- R7: An auto-refresh is issued exactly at the end of the non-read exit wait after a self-refresh exit. The refresh interval restarts at the exit.
- R8: A power-down entry drives cke 0 in the entry cycle. cke stays 0, with no command, until the power-down exit cycle, which drives cke 1.
- R9: After a power-down exit, PDX_CYC (1) cycles follow with no command and all permits 0. A refresh that fell due during power-down is issued in the first cycle after that wait. None is issued during power-down.
- R10: A self-refresh or power-down entry request that arrives during the refresh recovery wait is held off. It is served RFC_CYC cycles after the refresh.
- R11: At most one command per cycle. A due refresh wins over entry requests. A self-refresh entry request wins over a power-down entry request.
- R12: Command codes are: 0 none, 1 auto-refresh, 2 self-refresh entry, 3 self-refresh exit, 4 power-down entry, 5 power-down exit. cmdCode is 0 whenever cmdValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refInterval | input | CNT_W | Cycles between auto-refresh commands |
| fastClk | input | 1 | Selects the longer non-read exit wait for the faster clock |
| selfEnterReq | input | 1 | Level request to enter self-refresh |
| selfExitReq | input | 1 | Level request to leave self-refresh |
| pdEnterReq | input | 1 | Level request to enter power-down |
| pdExitReq | input | 1 | Level request to leave power-down |
| cmdValid | output | 1 | A command is strobed this cycle |
| cmdCode | output | 3 | Command code (see R12) |
| cke | output | 1 | Clock-enable level towards the memory |
| permitActMrs | output | 1 | Row activation and mode-register write allowed |
| permitNonRead | output | 1 | Other non-read commands allowed |
| permitRead | output | 1 | Read commands allowed |

## Verification
The embedded properties check, on every cycle, that cke stays low in the cycle after a self-refresh or power-down entry unless an exit follows. They also check that the power-down exit is followed by a silent cycle, and that each wait blocks its permit in the cycle after its trigger. The exact cycle counts are shown only by the bench's scenarios. These include the refresh spacing for several intervals, the end of each exit wait under both clock settings, the delayed entry during refresh recovery, the refresh that is deferred across power-down, and the priority between a due refresh and simultaneous entry requests.

// File: rtl/rlp_pkg.sv
`timescale 1ns/1ps
package rlp_pkg;
  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_REF      = 3'd1,
    CMD_SR_ENTER = 3'd2,
    CMD_SR_EXIT  = 3'd3,
    CMD_PD_ENTER = 3'd4,
    CMD_PD_EXIT  = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    ST_ACTIVE,
    ST_PWRDN,
    ST_PDWAIT,
    ST_SELFREF
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntRun;
    logic cntRestart;
    logic ldRfc;
    logic ldExit;
    logic ldSettle;
    logic ldPdx;
  } ctl_strobes_t;

  // status from datapath to control
  typedef struct packed {
    logic due;
    logic rfcBusy;
    logic exitBusy;
    logic settleBusy;
    logic pdxBusy;
    logic pendExit;
    logic refDone;
  } dp_status_t;
endpackage

// File: rtl/rlp_wait_ctr.sv
`timescale 1ns/1ps
module rlp_wait_ctr #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ldVal,
  output logic         busy
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (ld)         cnt <= ldVal;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rlp_timers.sv
`timescale 1ns/1ps
module rlp_timers
  import rlp_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int RFC_CYC        = 8,
  parameter int EXIT_WAIT_SLOW = 10,
  parameter int EXIT_WAIT_FAST = 12,
  parameter int READ_SETTLE    = 200,
  parameter int PDX_CYC        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] refInterval,
  input  logic             fastClk,
  input  ctl_strobes_t     ctl,
  output dp_status_t       sts
);
  localparam int EXIT_MAX = (EXIT_WAIT_FAST > EXIT_WAIT_SLOW) ? EXIT_WAIT_FAST : EXIT_WAIT_SLOW;
  localparam int RFC_W    = $clog2(RFC_CYC + 1);
  localparam int EXIT_W   = $clog2(EXIT_MAX + 1);
  localparam int SET_W    = $clog2(READ_SETTLE + 1);
  localparam int PDX_W    = $clog2(PDX_CYC + 1);

  logic [CNT_W-1:0] rfshCnt;
  logic             pendExit;
  logic             refDone;
  logic [EXIT_W-1:0] exitLoad;

  // interval counter: saturates, so a due refresh stays due while blocked
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               rfshCnt <= '0;
    else if (ctl.cntRestart)                  rfshCnt <= CNT_W'(1);
    else if (ctl.cntRun && (rfshCnt != '1))   rfshCnt <= rfshCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendExit <= 1'b0;
      refDone  <= 1'b0;
    end else begin
      if (ctl.ldExit)     pendExit <= 1'b1;
      else if (ctl.ldRfc) pendExit <= 1'b0;
      if (ctl.ldRfc)      refDone  <= 1'b1;
    end
  end

  assign exitLoad = fastClk ? EXIT_W'(EXIT_WAIT_FAST - 1) : EXIT_W'(EXIT_WAIT_SLOW - 1);

  rlp_wait_ctr #(.W(RFC_W)) i_rfcWait (
    .clk(clk), .rst_n(rst_n), .ld(ctl.ldRfc),
    .ldVal(RFC_W'(RFC_CYC - 1)), .busy(sts.rfcBusy));

  rlp_wait_ctr #(.W(EXIT_W)) i_exitWait (
    .clk(clk), .rst_n(rst_n), .ld(ctl.ldExit),
    .ldVal(exitLoad), .busy(sts.exitBusy));

  rlp_wait_ctr #(.W(SET_W)) i_settleWait (
    .clk(clk), .rst_n(rst_n), .ld(ctl.ldSettle),
    .ldVal(SET_W'(READ_SETTLE - 1)), .busy(sts.settleBusy));

  rlp_wait_ctr #(.W(PDX_W)) i_pdxWait (
    .clk(clk), .rst_n(rst_n), .ld(ctl.ldPdx),
    .ldVal(PDX_W'(PDX_CYC - 1)), .busy(sts.pdxBusy));

  assign sts.due      = (rfshCnt >= refInterval);
  assign sts.pendExit = pendExit;
  assign sts.refDone  = refDone;
endmodule

// File: rtl/rlp_ctrl.sv
`timescale 1ns/1ps
module rlp_ctrl
  import rlp_pkg::*;
#(
  parameter int RFC_CYC        = 8,
  parameter int EXIT_WAIT_SLOW = 10,
  parameter int EXIT_WAIT_FAST = 12,
  parameter int READ_SETTLE    = 200
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         selfEnterReq,
  input  logic         selfExitReq,
  input  logic         pdEnterReq,
  input  logic         pdExitReq,
  input  dp_status_t   sts,
  output ctl_strobes_t ctl,
  output cmd_e         cmdCode,
  output logic         cmdValid,
  output logic         cke,
  output logic         permitActMrs,
  output logic         permitNonRead,
  output logic         permitRead
);
  state_e st, stNxt;
  logic   permitBase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_ACTIVE;
    else        st <= stNxt;
  end

  always_comb begin
    stNxt   = st;
    cmdCode = CMD_NOP;
    ctl     = '0;
    cke     = 1'b1;
    case (st)
      ST_ACTIVE: begin
        ctl.cntRun = 1'b1;
        if (!sts.rfcBusy && !sts.exitBusy) begin
          if (sts.due || sts.pendExit) begin
            cmdCode        = CMD_REF;
            ctl.ldRfc      = 1'b1;
            ctl.cntRestart = 1'b1;
          end else if (selfEnterReq) begin
            cmdCode = CMD_SR_ENTER;
            cke     = 1'b0;
            stNxt   = ST_SELFREF;
          end else if (pdEnterReq) begin
            cmdCode = CMD_PD_ENTER;
            cke     = 1'b0;
            stNxt   = ST_PWRDN;
          end
        end
      end
      ST_SELFREF: begin
        cke            = 1'b0;
        ctl.cntRestart = 1'b1;
        if (selfExitReq) begin
          cmdCode      = CMD_SR_EXIT;
          cke          = 1'b1;
          ctl.ldExit   = 1'b1;
          ctl.ldSettle = 1'b1;
          stNxt        = ST_ACTIVE;
        end
      end
      ST_PWRDN: begin
        cke        = 1'b0;
        ctl.cntRun = 1'b1;
        if (pdExitReq) begin
          cmdCode    = CMD_PD_EXIT;
          cke        = 1'b1;
          ctl.ldPdx  = 1'b1;
          stNxt      = ST_PDWAIT;
        end
      end
      ST_PDWAIT: begin
        ctl.cntRun = 1'b1;
        if (!sts.pdxBusy) stNxt = ST_ACTIVE;
      end
      default: stNxt = ST_ACTIVE;
    endcase
  end

  assign cmdValid      = (cmdCode != CMD_NOP);
  assign permitBase    = (st == ST_ACTIVE) && sts.refDone && !sts.exitBusy && !cmdValid;
  assign permitActMrs  = permitBase && !sts.rfcBusy;
  assign permitNonRead = permitBase;
  assign permitRead    = permitBase && !sts.settleBusy;

  // R4
  sr_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_SR_ENTER) |=> (!cke || cmdCode == CMD_SR_EXIT));

  // R8
  pd_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_PD_ENTER) |=> (!cke || cmdCode == CMD_PD_EXIT));

  // R9
  pdx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdCode == CMD_PD_EXIT) |=> (!cmdValid && !permitNonRead && !permitRead));

  if (RFC_CYC > 1) begin : g_rfcChk
    // R3
    rfc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmdCode == CMD_REF) |=> !permitActMrs);
  end

  if ((EXIT_WAIT_SLOW > 1) && (EXIT_WAIT_FAST > 1) && (READ_SETTLE > 1)) begin : g_exitChk
    // R5
    exit_nonread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmdCode == CMD_SR_EXIT) |=> (!permitNonRead && !cmdValid));
    // R6
    exit_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmdCode == CMD_SR_EXIT) |=> !permitRead);
  end
endmodule

// File: rtl/refresh_lp_seq.sv
`timescale 1ns/1ps
module refresh_lp_seq
  import rlp_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int RFC_CYC        = 8,
  parameter int EXIT_WAIT_SLOW = 10,
  parameter int EXIT_WAIT_FAST = 12,
  parameter int READ_SETTLE    = 200,
  parameter int PDX_CYC        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] refInterval,
  input  logic             fastClk,
  input  logic             selfEnterReq,
  input  logic             selfExitReq,
  input  logic             pdEnterReq,
  input  logic             pdExitReq,
  output logic             cmdValid,
  output logic [2:0]       cmdCode,
  output logic             cke,
  output logic             permitActMrs,
  output logic             permitNonRead,
  output logic             permitRead
);
  ctl_strobes_t ctl;
  dp_status_t   sts;
  cmd_e         cmdE;

  rlp_ctrl #(
    .RFC_CYC(RFC_CYC), .EXIT_WAIT_SLOW(EXIT_WAIT_SLOW),
    .EXIT_WAIT_FAST(EXIT_WAIT_FAST), .READ_SETTLE(READ_SETTLE)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .selfEnterReq(selfEnterReq), .selfExitReq(selfExitReq),
    .pdEnterReq(pdEnterReq), .pdExitReq(pdExitReq),
    .sts(sts), .ctl(ctl), .cmdCode(cmdE), .cmdValid(cmdValid), .cke(cke),
    .permitActMrs(permitActMrs), .permitNonRead(permitNonRead), .permitRead(permitRead));

  rlp_timers #(
    .CNT_W(CNT_W), .RFC_CYC(RFC_CYC), .EXIT_WAIT_SLOW(EXIT_WAIT_SLOW),
    .EXIT_WAIT_FAST(EXIT_WAIT_FAST), .READ_SETTLE(READ_SETTLE), .PDX_CYC(PDX_CYC)
  ) i_timers (
    .clk(clk), .rst_n(rst_n), .refInterval(refInterval), .fastClk(fastClk),
    .ctl(ctl), .sts(sts));

  assign cmdCode = cmdE;
endmodule

// File: tb/test_refresh_lp_seq.sv
`timescale 1ns/1ps
module test_refresh_lp_seq;
  localparam int C_NOP = 0, C_REF = 1, C_SRE = 2, C_SRX = 3, C_PDE = 4, C_PDX = 5;

  typedef struct packed { int intv; int first; int gap; } vec_t;
  localparam int NVEC = 4;
  localparam vec_t VEC [NVEC] = '{'{12, 12, 12}, '{25, 25, 25}, '{47, 47, 47}, '{90, 90, 90}};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] refInterval = 16'd30;
  logic        fastClk = 1'b0;
  logic        selfEnterReq = 1'b0, selfExitReq = 1'b0, pdEnterReq = 1'b0, pdExitReq = 1'b0;
  logic        cmdValid, cke, permitActMrs, permitNonRead, permitRead;
  logic [2:0]  cmdCode;

  int nTests = 0, nFail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  refresh_lp_seq i_refresh_lp_seq (
    .clk(clk), .rst_n(rst_n), .refInterval(refInterval), .fastClk(fastClk),
    .selfEnterReq(selfEnterReq), .selfExitReq(selfExitReq),
    .pdEnterReq(pdEnterReq), .pdExitReq(pdExitReq),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .cke(cke),
    .permitActMrs(permitActMrs), .permitNonRead(permitNonRead), .permitRead(permitRead));

  task automatic tick();
    @(posedge clk); #3;
  endtask

  task automatic chkEq(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
  endtask

  function automatic bit isRef();
    return cmdValid && (cmdCode == 3'(C_REF));
  endfunction

  // self-refresh exit with the given non-read wait
  task automatic exitCheck(input int snr, input string tag);
    selfExitReq = 1'b1; #1;
    chkEq({"R12 exit code ", tag}, cmdCode, C_SRX);
    chkEq({"R4 cke high on exit ", tag}, cke, 1);
    tick(); selfExitReq = 1'b0; #1;
    chkEq({"R5 non-read blocked after exit ", tag}, permitNonRead, 0);
    repeat (snr - 2) tick();
    chkEq({"R5 non-read blocked one cycle early ", tag}, permitNonRead, 0);
    chkEq({"R7 no refresh before wait end ", tag}, cmdValid, 0);
    tick();
    chkEq({"R7 forced refresh at wait end ", tag}, cmdCode, C_REF);
    tick();
    chkEq({"R5 non-read allowed ", tag}, permitNonRead, 1);
    chkEq({"R6 read still blocked ", tag}, permitRead, 0);
    repeat (198 - snr) tick();
    chkEq({"R6 read blocked one cycle early ", tag}, permitRead, 0);
    tick();
    chkEq({"R6 read allowed at settle end ", tag}, permitRead, 1);
  endtask

  initial begin : watchdog
    #2000000;
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : main
    int n, bad;
    bit early;

    // table of refresh intervals: first refresh and spacing (R2)
    for (int v = 0; v < NVEC; v++) begin
      refInterval = 16'(VEC[v].intv);
      doReset();
      if (v == 0) begin
        chkEq("R1 cke after reset", cke, 1);
        chkEq("R1 no command after reset", cmdValid, 0);
        chkEq("R12 idle code is zero", cmdCode, C_NOP);
      end
      n = 0; early = 0;
      while (!isRef() && n < 2000) begin
        if (permitActMrs || permitNonRead || permitRead) early = 1;
        tick(); n++;
      end
      chkEq("R2 first refresh cycle", n, VEC[v].first);
      if (v == 0) chkEq("R1 permits low before first refresh", early, 0);
      tick(); n = 1;
      while (!isRef() && n < 2000) begin tick(); n++; end
      chkEq("R2 refresh spacing", n, VEC[v].gap);
    end

    // recovery wait after refresh
    refInterval = 16'd30;
    doReset();
    n = 0;
    while (!isRef() && n < 2000) begin tick(); n++; end
    tick();
    chkEq("R3 non-read free during recovery", permitNonRead, 1);
    chkEq("R3 activate blocked after refresh", permitActMrs, 0);
    repeat (6) tick();
    chkEq("R3 activate blocked one cycle early", permitActMrs, 0);
    tick();
    chkEq("R3 activate allowed at recovery end", permitActMrs, 1);
    repeat (22) tick();
    chkEq("R2 second refresh after interval", cmdCode, C_REF);

    // entry held during recovery
    tick(); refInterval = 16'd1000; selfEnterReq = 1'b1; #1;
    chkEq("R10 entry held during recovery", cmdValid, 0);
    repeat (6) tick();
    chkEq("R10 entry still held one cycle early", cmdValid, 0);
    tick();
    chkEq("R10 self-refresh entry at recovery end", cmdCode, C_SRE);
    chkEq("R4 cke low with entry", cke, 0);
    tick(); selfEnterReq = 1'b0; #1;
    bad = 0;
    repeat (1500) begin if (cke || cmdValid) bad++; tick(); end
    chkEq("R4 self-refresh residency quiet", bad, 0);

    fastClk = 1'b0;
    exitCheck(10, "slow");

    selfEnterReq = 1'b1; #1;
    chkEq("R4 second self-refresh entry", cmdCode, C_SRE);
    tick(); selfEnterReq = 1'b0; #1;
    repeat (50) tick();
    fastClk = 1'b1;
    exitCheck(12, "fast");

    // power-down without pending refresh
    pdEnterReq = 1'b1; #1;
    chkEq("R12 power-down entry code", cmdCode, C_PDE);
    chkEq("R8 cke low at entry", cke, 0);
    tick(); pdEnterReq = 1'b0; #1;
    bad = 0;
    repeat (20) begin if (cke || cmdValid) bad++; tick(); end
    chkEq("R8 power-down residency quiet", bad, 0);
    pdExitReq = 1'b1; #1;
    chkEq("R12 power-down exit code", cmdCode, C_PDX);
    chkEq("R8 cke high on exit", cke, 1);
    tick(); pdExitReq = 1'b0; #1;
    chkEq("R9 no command in exit wait", cmdValid, 0);
    chkEq("R9 permits low in exit wait", int'({permitActMrs, permitNonRead, permitRead}), 0);
    tick();
    chkEq("R9 permits back after exit wait", permitNonRead, 1);

    // refresh falling due during power-down
    refInterval = 16'd40; #1;
    chkEq("R2 refresh when interval lowered", cmdCode, C_REF);
    repeat (8) tick();
    pdEnterReq = 1'b1; #1;
    chkEq("R8 power-down entry", cmdCode, C_PDE);
    tick(); pdEnterReq = 1'b0; #1;
    bad = 0;
    repeat (51) begin if (cke || cmdValid) bad++; tick(); end
    chkEq("R9 refresh blocked in power-down", bad, 0);
    pdExitReq = 1'b1; #1;
    chkEq("R8 power-down exit", cmdCode, C_PDX);
    tick(); pdExitReq = 1'b0; #1;
    chkEq("R9 quiet exit wait with refresh pending", cmdValid, 0);
    tick();
    chkEq("R9 pending refresh after exit wait", cmdCode, C_REF);

    // priority
    repeat (40) tick();
    selfEnterReq = 1'b1; pdEnterReq = 1'b1; #1;
    chkEq("R11 due refresh wins over entries", cmdCode, C_REF);
    repeat (7) tick();
    chkEq("R11 entries wait out recovery", cmdValid, 0);
    tick();
    chkEq("R11 self-refresh wins over power-down", cmdCode, C_SRE);
    tick(); selfEnterReq = 1'b0; pdEnterReq = 1'b0; #1;
    chkEq("R4 in self-refresh after priority test", cke, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule